// File: doc/BRIEF.md
# Alignment character inserter

This block sits on the transmit side of a serial converter link, after the sequencer that produces the user-data octet stream. Scrambling is assumed to be off. Two strobes mark the octet that closes a frame and the octet that closes a multiframe. At each of these closing positions, the octet is compared with the octet that held the same role one frame or one multiframe earlier. When the two are equal, the data octet is replaced by a control character. The receiver knows that the replaced value equals the earlier one, so it can restore the value. It can also use the control character to confirm its frame and multiframe boundaries, and no payload is lost.

Substitution happens only while the data-phase enable is high. Octets sent while the enable is low pass through unchanged, including the synchronisation and lane-alignment sequences. Every octet leaves the block exactly one clock after it enters. Its valid and control flags travel with it.

Top module: `align_char_inserter`

## Requirements
- R1: While reset is applied, and until the internal reset synchroniser releases, `out_vld`, `out_k` and `out_data` are all zero.
- R2: An octet that is not substituted leaves on `out_data`/`out_k` exactly one clock after it was presented on `in_data`/`in_k`, with its value unchanged.
- R3: A valid data octet (`in_k`=0) at a frame end (`in_eof`=1, `in_eomf`=0) is replaced, if it equals the data octet of the previous frame end, by 0xFC with `out_k`=1.
- R4: A valid data octet at a multiframe end (`in_eomf`=1) is replaced, if it equals the data octet of the previous multiframe end, by 0x7C with `out_k`=1.
- R5: At a multiframe end only the multiframe comparison is applied. A match with the previous frame end alone causes no substitution, and 0xFC is never sent there.
- R6: The stored previous end octets always hold the original data values, never a substituted code. A value that repeats for many frames in a row is replaced at every repetition.
- R7: While `data_en` is 0, every octet passes unchanged and the stored history is discarded. After `data_en` rises, the first frame end and the first multiframe end are never substituted.
- R8: Octets with `in_k`=1, and cycles with `in_vld`=0, pass unchanged and do not update the stored history.
- R9: `out_vld` equals `in_vld` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input octet valid |
| in_data | input | W | Input octet |
| in_k | input | 1 | Input octet is a control character |
| data_en | input | 1 | User-data phase enable |
| in_eof | input | 1 | Octet closes a frame |
| in_eomf | input | 1 | Octet closes a multiframe (also a frame end) |
| out_vld | output | 1 | Output octet valid |
| out_data | output | W | Output octet |
| out_k | output | 1 | Output octet is a control character |

## Verification
A constant data stream makes every frame end and multiframe end a repeat. It shows that the stored history keeps raw data across back-to-back substitutions, and that multiframe priority applies. A ramp changes every octet, so any substitution it produces is a false compare. A random pass draws from a small alphabet and mixes in control octets, idle cycles and toggles of the data-phase enable. It separates the frame-end match from the multiframe-end match, and it shows how history behaves on skipped octets and when the enable drops.

// File: rtl/aci_pkg.sv
package aci_pkg;
  localparam int unsigned OCTET_W = 8;
  localparam logic [OCTET_W-1:0] CODE_FRAME = 8'hFC; // frame alignment control
  localparam logic [OCTET_W-1:0] CODE_MFRM  = 8'h7C; // multiframe alignment control

  typedef enum logic [1:0] {
    SEL_PASS  = 2'd0,
    SEL_FRAME = 2'd1,
    SEL_MFRM  = 2'd2
  } sel_e;
endpackage

// File: rtl/aci_rst_sync.sv
module aci_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_s = chain_q[STAGES-1];
endmodule

// File: rtl/aci_end_history.sv
module aci_end_history #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         phase_en,
  input  logic         cap_frame,
  input  logic         cap_mfrm,
  input  logic [W-1:0] cap_data,
  output logic [W-1:0] frame_val,
  output logic         frame_have,
  output logic [W-1:0] mfrm_val,
  output logic         mfrm_have
);
  logic [W-1:0] frame_val_d, mfrm_val_d;
  logic         frame_have_d, mfrm_have_d;
  logic         frame_we, mfrm_we;

  always_comb begin
    frame_we     = phase_en & cap_frame;
    mfrm_we      = phase_en & cap_mfrm;
    frame_val_d  = frame_we ? cap_data : frame_val;
    mfrm_val_d   = mfrm_we  ? cap_data : mfrm_val;
    frame_have_d = phase_en & (frame_have | cap_frame);
    mfrm_have_d  = phase_en & (mfrm_have  | cap_mfrm);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_have <= 1'b0;
      mfrm_have  <= 1'b0;
    end else begin
      frame_have <= frame_have_d;
      mfrm_have  <= mfrm_have_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_val <= '0;
    else if (frame_we) frame_val <= frame_val_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mfrm_val <= '0;
    else if (mfrm_we) mfrm_val <= mfrm_val_d;
  end

  // R7: leaving the data phase discards history
  p_hist_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_en |=> (!frame_have && !mfrm_have));
  // R8: no capture request leaves the stored octets untouched
  p_hist_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_frame |=> $stable(frame_val));
endmodule

// File: rtl/aci_sub_select.sv
module aci_sub_select
  import aci_pkg::*;
#(
  parameter int unsigned     W      = 8,
  parameter logic [W-1:0]    F_CODE = CODE_FRAME,
  parameter logic [W-1:0]    M_CODE = CODE_MFRM
) (
  input  logic         live,
  input  logic         at_eof,
  input  logic         at_eomf,
  input  logic [W-1:0] d_in,
  input  logic         k_in,
  input  logic [W-1:0] frame_val,
  input  logic         frame_have,
  input  logic [W-1:0] mfrm_val,
  input  logic         mfrm_have,
  output logic [W-1:0] d_out,
  output logic         k_out
);
  sel_e sel;

  always_comb begin
    sel = SEL_PASS;
    if (live) begin
      if (at_eomf) begin
        if (mfrm_have && (d_in == mfrm_val)) sel = SEL_MFRM;
      end else if (at_eof) begin
        if (frame_have && (d_in == frame_val)) sel = SEL_FRAME;
      end
    end
    unique case (sel)
      SEL_FRAME: begin d_out = F_CODE; k_out = 1'b1; end
      SEL_MFRM:  begin d_out = M_CODE; k_out = 1'b1; end
      default:   begin d_out = d_in;   k_out = k_in; end
    endcase
  end
endmodule

// File: rtl/aci_out_stage.sv
module aci_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_d,
  input  logic [W-1:0] data_d,
  input  logic         k_d,
  output logic         vld_q,
  output logic [W-1:0] data_q,
  output logic         k_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      k_q    <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      data_q <= data_d;
      k_q    <= k_d;
    end
  end
endmodule

// File: rtl/align_char_inserter.sv
module align_char_inserter
  import aci_pkg::*;
#(
  parameter int unsigned  W           = OCTET_W,
  parameter int unsigned  SYNC_STAGES = 2,
  parameter logic [W-1:0] F_CODE      = CODE_FRAME,
  parameter logic [W-1:0] M_CODE      = CODE_MFRM
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_data,
  input  logic         in_k,
  input  logic         data_en,
  input  logic         in_eof,
  input  logic         in_eomf,
  output logic         out_vld,
  output logic [W-1:0] out_data,
  output logic         out_k
);
  logic         rst_s;
  logic         live;
  logic         cap_frame, cap_mfrm;
  logic [W-1:0] frame_val, mfrm_val;
  logic         frame_have, mfrm_have;
  logic [W-1:0] sel_data;
  logic         sel_k;

  aci_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s(rst_s));

  always_comb begin
    live      = in_vld & data_en & ~in_k;
    cap_frame = live & (in_eof | in_eomf);
    cap_mfrm  = live & in_eomf;
  end

  aci_end_history #(.W(W)) u_hist (
    .clk(clk), .rst_n(rst_s), .phase_en(data_en),
    .cap_frame(cap_frame), .cap_mfrm(cap_mfrm), .cap_data(in_data),
    .frame_val(frame_val), .frame_have(frame_have),
    .mfrm_val(mfrm_val), .mfrm_have(mfrm_have));

  aci_sub_select #(.W(W), .F_CODE(F_CODE), .M_CODE(M_CODE)) u_sel (
    .live(live), .at_eof(in_eof), .at_eomf(in_eomf),
    .d_in(in_data), .k_in(in_k),
    .frame_val(frame_val), .frame_have(frame_have),
    .mfrm_val(mfrm_val), .mfrm_have(mfrm_have),
    .d_out(sel_data), .k_out(sel_k));

  aci_out_stage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_s),
    .vld_d(in_vld), .data_d(sel_data), .k_d(sel_k),
    .vld_q(out_vld), .data_q(out_data), .k_q(out_k));

  // R9: valid travels with one clock of delay
  p_vld_latency_r9: assert property (@(posedge clk) disable iff (!rst_s)
    out_vld == $past(in_vld));
  // R7: a new control flag only appears for data-phase valid octets
  p_sub_in_phase_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (out_k && !$past(in_k)) |-> $past(data_en && in_vld));
  // R3/R4: substituted octets carry one of the two codes
  p_sub_code_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (out_k && !$past(in_k)) |-> (out_data == F_CODE || out_data == M_CODE));
  // R5: multiframe ends never carry the frame code
  p_mfrm_prio_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (out_k && !$past(in_k) && $past(in_eomf)) |-> out_data == M_CODE);
  // R8: control octets leave unchanged
  p_k_pass_r8: assert property (@(posedge clk) disable iff (!rst_s)
    $past(in_k) |-> (out_k && out_data == $past(in_data)));
endmodule

// File: tb/sim_align_char_inserter.sv
`timescale 1ns/1ps
module sim_align_char_inserter;
  localparam int FRM = 4;   // octets per frame
  localparam int MFK = 3;   // frames per multiframe

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0, in_k = 1'b0, data_en = 1'b0, in_eof = 1'b0, in_eomf = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic out_vld, out_k;
  logic [7:0] out_data;

  int errors = 0, checks = 0;
  bit done = 0;

  // behavioural reference state
  int prev_f = -1, prev_m = -1;
  bit pend = 0;
  bit exp_v, exp_k;
  int exp_d;
  string exp_tag, phase_tag;
  int pos = 0, frm = 0;

  always #4 clk = ~clk; // 125 MHz

  align_char_inserter u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data), .in_k(in_k),
    .data_en(data_en), .in_eof(in_eof), .in_eomf(in_eomf),
    .out_vld(out_vld), .out_data(out_data), .out_k(out_k));

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) %s: actual=%0h expected=%0h", tag, phase_tag, what, act, exp);
    end
  endtask

  task automatic compare_pending();
    if (pend) begin
      check(out_vld == exp_v, "R9", "valid", out_vld, exp_v);
      check(out_data == exp_d[7:0] && out_k == exp_k, exp_tag, "octet/k",
            {out_k, out_data}, {exp_k, exp_d[7:0]});
    end
  endtask

  task automatic step(input bit v, input bit [7:0] d, input bit k, input bit en, input bit eof, input bit eomf);
    @(negedge clk);
    compare_pending();
    in_vld = v; in_data = d; in_k = k; data_en = en; in_eof = eof; in_eomf = eomf;
    exp_v = v; exp_d = d; exp_k = k; exp_tag = "R2";
    if (!en) begin
      prev_f = -1; prev_m = -1; exp_tag = "R7";
    end else if (v && !k) begin
      if (eomf) begin
        exp_tag = "R5";
        if (prev_m == int'(d)) begin exp_d = 8'h7C; exp_k = 1; exp_tag = "R4"; end
      end else if (eof && prev_f == int'(d)) begin
        exp_d = 8'hFC; exp_k = 1; exp_tag = "R3";
      end
      if (eof || eomf) prev_f = d;
      if (eomf) prev_m = d;
    end else exp_tag = "R8";
    pend = 1;
  endtask

  // one octet at the running frame position; position moves on valid octets only
  task automatic slot(input bit v, input bit [7:0] d, input bit k, input bit en);
    bit eof, eomf;
    eof  = v && (pos == FRM-1);
    eomf = eof && (frm == MFK-1);
    step(v, d, k, en, eof, eomf);
    if (v) begin
      if (pos == FRM-1) begin pos = 0; frm = (frm == MFK-1) ? 0 : frm + 1; end
      else pos++;
    end
  endtask

  initial begin
    phase_tag = "R1";
    repeat (3) begin
      @(negedge clk);
      check(out_vld == 0 && out_k == 0 && out_data == 0, "R1", "reset outputs",
            {out_vld, out_k, out_data}, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check(out_vld == 0 && out_data == 0, "R1", "sync release", {out_vld, out_data}, 0);
    repeat (4) @(negedge clk);

    phase_tag = "R7 phase off";
    for (int i = 0; i < 3*FRM*MFK; i++) slot(1, 8'h5A, 0, 0);

    phase_tag = "R6 constant";
    for (int i = 0; i < 4*FRM*MFK; i++) slot(1, 8'h5A, 0, 1);

    phase_tag = "R2 ramp";
    for (int i = 0; i < 4*FRM*MFK; i++) slot(1, 8'(i), 0, 1);

    phase_tag = "R7 reenable";
    slot(1, 8'h11, 0, 0);
    for (int i = 0; i < 2*FRM*MFK; i++) slot(1, 8'h33, 0, 1);

    phase_tag = "R8 random";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      slot(r > 10, 8'($urandom_range(0, 2)), r > 90, !(r == 5 || r == 6));
    end

    @(negedge clk);
    compare_pending();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule